// File: doc/BRIEF.md
# Parity Error Address Capture Unit

This unit sits beside a small result memory whose 32-bit words each carry one even-parity bit. On every memory write it supplies the parity bit and keeps it in its own parity store. On every memory read it recomputes parity over the returned data and compares it with the stored bit. Each mismatch gives a one-cycle error pulse.

The word address of the first failing read is latched into a read-only 32-bit status register. The address field sits at bits 11:2, so the low twelve bits form a 32-bit-aligned byte address. Once an address is latched, the register is frozen and later errors leave it alone. A register read strobe re-arms it, but only when the debug input is low. A debugger can therefore inspect the register without losing the record.

A test input flips the stored parity bit of one word so that errors can be injected.

Top module: `parity_err_capture`

## Requirements
- R1: `wr_par_o` equals the XOR of all bits of `wr_data_i` (even parity), combinationally.
- R2: A read (`rd_en_i`=1) is in error when the XOR of `rd_data_i` and the stored parity bit of `rd_addr_i` is 1. `err_pulse_o` is high for exactly the one cycle after each erroneous read, whether or not the register is frozen. It stays low after clean reads.
- R3: When not frozen, an erroneous read latches `rd_addr_i` into `rdata_o[11:2]` at the same clock edge that raises `err_pulse_o`, and the register becomes frozen.
- R4: While frozen, further errors do not change `rdata_o[11:2]`.
- R5: A register read (`reg_rd_i`=1 with `dbg_i`=0) returns the current contents on `rdata_o` and releases the freeze, so the next error is latched.
- R6: A register read with `dbg_i`=1 leaves the register frozen.
- R7: An erroneous memory read in the same cycle as a releasing register read is latched: the register holds the new address afterwards.
- R8: `rdata_o[31:12]` and `rdata_o[1:0]` read as zero at all times, including after reset. The address field has no defined reset value.
- R9: `inj_en_i` inverts the stored parity bit of word `inj_addr_i`, so that a later read of that word's data is an error. Writing the word again stores fresh, correct parity.
- R10: After reset the register is not frozen, so the first error is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Memory write strobe |
| wr_addr_i | input | 10 | Memory write word address |
| wr_data_i | input | 32 | Memory write data |
| wr_par_o | output | 1 | Even parity of write data |
| rd_en_i | input | 1 | Memory read strobe, data valid |
| rd_addr_i | input | 10 | Memory read word address |
| rd_data_i | input | 32 | Data returned by the memory |
| err_pulse_o | output | 1 | One-cycle parity error pulse |
| inj_en_i | input | 1 | Invert a stored parity bit (test) |
| inj_addr_i | input | 10 | Word whose parity bit is inverted |
| reg_rd_i | input | 1 | Status register read strobe |
| dbg_i | input | 1 | Debug mode: reads do not release |
| rdata_o | output | 32 | Status register contents |

## Verification
The bench latches a first error and then triggers a second error while frozen. A design that overwrote on every error would show the second address. It reads the register in debug mode and then triggers another error. A design that released on any read would pick up that later address. It collides a releasing read with a fresh error in one cycle. A design that cleared after capturing, or ignored errors during the release, would lose the address at the top of the range (0x3FF). Parity injection followed by a rewrite catches a store that fails to invert a bit, or fails to refresh it on write.

// File: rtl/parcap_pkg.sv
package parcap_pkg;
  localparam int REG_W     = 32;
  localparam int FIELD_LSB = 2;

  function automatic logic even_par32(input logic [31:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/parcap_store.sv
module parcap_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              wr_par_o,
  output logic              rd_par_o
);
  logic [DEPTH-1:0] par_vec;

  assign wr_par_o = ^wr_data_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic bit_q;
    logic wr_hit, inj_hit;
    assign wr_hit  = wr_en_i  && (wr_addr_i  == ADDR_W'(i));
    assign inj_hit = inj_en_i && (inj_addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               bit_q <= 1'b0;
      else if (wr_hit || inj_hit) bit_q <= (wr_hit ? wr_par_o : bit_q) ^ inj_hit;
    end
    assign par_vec[i] = bit_q;
  end

  assign rd_par_o = par_vec[rd_addr_i];
endmodule

// File: rtl/parcap_check.sv
module parcap_check #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_par_i,
  output logic              mismatch_o,
  output logic              err_pulse_o
);
  assign mismatch_o = rd_en_i && ((^rd_data_i) ^ rd_par_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_pulse_o <= 1'b0;
    else         err_pulse_o <= mismatch_o;
  end
endmodule

// File: rtl/parcap_freeze.sv
module parcap_freeze #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mismatch_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              reg_rd_i,
  input  logic              dbg_i,
  output logic              frozen_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic release_w, capture_w;

  // release is evaluated before capture so a colliding error is kept
  assign release_w = reg_rd_i && !dbg_i;
  assign capture_w = mismatch_i && (!frozen_o || release_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frozen_o <= 1'b0;
    else if (capture_w) frozen_o <= 1'b1;
    else if (release_w) frozen_o <= 1'b0;
  end

  // address field has no reset value
  always_ff @(posedge clk_i) begin
    if (capture_w) addr_o <= rd_addr_i;
  end
endmodule

// File: rtl/parity_err_capture.sv
module parity_err_capture
  import parcap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_par_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              err_pulse_o,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic              reg_rd_i,
  input  logic              dbg_i,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int HI_PAD = REG_W - ADDR_W - FIELD_LSB;

  logic              rd_par_w;
  logic              mismatch_w;
  logic              frozen_w;
  logic [ADDR_W-1:0] cap_addr_w;

  parcap_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .inj_en_i   (inj_en_i),
    .inj_addr_i (inj_addr_i),
    .rd_addr_i  (rd_addr_i),
    .wr_par_o   (wr_par_o),
    .rd_par_o   (rd_par_w)
  );

  parcap_check #(.DATA_W(DATA_W)) u_check (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .rd_data_i   (rd_data_i),
    .rd_par_i    (rd_par_w),
    .mismatch_o  (mismatch_w),
    .err_pulse_o (err_pulse_o)
  );

  parcap_freeze #(.ADDR_W(ADDR_W)) u_freeze (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mismatch_i (mismatch_w),
    .rd_addr_i  (rd_addr_i),
    .reg_rd_i   (reg_rd_i),
    .dbg_i      (dbg_i),
    .frozen_o   (frozen_w),
    .addr_o     (cap_addr_w)
  );

  assign rdata_o = {{HI_PAD{1'b0}}, cap_addr_w, {FIELD_LSB{1'b0}}};
endmodule

// File: rtl/parity_err_capture_chk.sv
module parity_err_capture_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              reg_rd_i,
  input logic              dbg_i,
  input logic              mismatch_i,
  input logic              frozen_i,
  input logic              err_pulse_i,
  input logic [31:0]       rdata_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[31:ADDR_W+2] == '0 && rdata_i[1:0] == 2'b00);  // R8

  AST_PULSE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_i |-> $past(rd_en_i));  // R2

  AST_FIRST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_i && (!frozen_i || (reg_rd_i && !dbg_i)))
    |=> (frozen_i && rdata_i[ADDR_W+1:2] == $past(rd_addr_i)));  // R3

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && !(reg_rd_i && !dbg_i)) |=> (frozen_i && $stable(rdata_i)));  // R4

  AST_DBG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && reg_rd_i && dbg_i) |=> frozen_i);  // R6

  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && reg_rd_i && !dbg_i && !mismatch_i) |=> !frozen_i);  // R5
endmodule

bind parity_err_capture parity_err_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .reg_rd_i    (reg_rd_i),
  .dbg_i       (dbg_i),
  .mismatch_i  (mismatch_w),
  .frozen_i    (frozen_w),
  .err_pulse_i (err_pulse_o),
  .rdata_i     (rdata_o)
);

// File: tb/sim_parity_err_capture.sv
`timescale 1ns/1ps
module sim_parity_err_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [9:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        wr_par_o;
  logic        rd_en_i = 1'b0;
  logic [9:0]  rd_addr_i = '0;
  logic [31:0] rd_data_i = '0;
  logic        err_pulse_o;
  logic        inj_en_i = 1'b0;
  logic [9:0]  inj_addr_i = '0;
  logic        reg_rd_i = 1'b0;
  logic        dbg_i = 1'b0;
  logic [31:0] rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] mem [1024];

  always #2 clk_i = ~clk_i;

  parity_err_capture u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic mem_write(input logic [9:0] a, input logic [31:0] d, input logic exp_par);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    #1 check("R1 write parity", {31'b0, wr_par_o}, {31'b0, exp_par});
    @(negedge clk_i);
    wr_en_i = 1'b0;
    mem[a] = d;
  endtask

  task automatic mem_read(input logic [9:0] a, input logic exp_pulse, input string req);
    rd_en_i = 1'b1; rd_addr_i = a; rd_data_i = mem[a];
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(req, {31'b0, err_pulse_o}, {31'b0, exp_pulse});
    @(negedge clk_i);
    check("R2 pulse one cycle", {31'b0, err_pulse_o}, 32'h0);
  endtask

  task automatic inject(input logic [9:0] a);
    inj_en_i = 1'b1; inj_addr_i = a;
    @(negedge clk_i);
    inj_en_i = 1'b0;
  endtask

  task automatic reg_read(input logic dbg, input logic [31:0] exp, input string req);
    reg_rd_i = 1'b1; dbg_i = dbg;
    #1 check(req, rdata_o, exp);
    @(negedge clk_i);
    reg_rd_i = 1'b0; dbg_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reserved bits after reset", rdata_o & 32'hFFFF_F003, 32'h0);
    check("R2 no pulse after reset", {31'b0, err_pulse_o}, 32'h0);
  endtask

  task automatic t_clean();
    mem_write(10'd5,   32'h0000_0007, 1'b1);
    mem_write(10'd9,   32'h1234_5678, 1'b1);
    mem_write(10'h3FF, 32'hFFFF_0000, 1'b0);
    mem_write(10'd12,  32'hA5A5_A5A5, 1'b0);
    mem_read(10'd5,   1'b0, "R2 clean read 5");
    mem_read(10'd9,   1'b0, "R2 clean read 9");
    mem_read(10'h3FF, 1'b0, "R2 clean read 3FF");
    mem_read(10'd12,  1'b0, "R2 clean read 12");
  endtask

  task automatic t_first();
    inject(10'd5);
    mem_read(10'd5, 1'b1, "R9 injected error pulses");
    check("R10 R3 first error latched", rdata_o, 32'h0000_0014);
  endtask

  task automatic t_hold();
    inject(10'd9);
    mem_read(10'd9, 1'b1, "R2 pulse while frozen");
    check("R4 frozen field unchanged", rdata_o, 32'h0000_0014);
  endtask

  task automatic t_dbg();
    reg_read(1'b1, 32'h0000_0014, "R6 debug read value");
    mem_read(10'd9, 1'b1, "R2 pulse after debug read");
    check("R6 debug read kept freeze", rdata_o, 32'h0000_0014);
  endtask

  task automatic t_release();
    reg_read(1'b0, 32'h0000_0014, "R5 release read value");
    mem_read(10'd9, 1'b1, "R2 pulse after release");
    check("R5 new error latched after release", rdata_o, 32'h0000_0024);
  endtask

  task automatic t_same_cycle();
    inject(10'h3FF);
    reg_rd_i = 1'b1; dbg_i = 1'b0;
    rd_en_i = 1'b1; rd_addr_i = 10'h3FF; rd_data_i = mem[10'h3FF];
    #1 check("R7 old value read", rdata_o, 32'h0000_0024);
    @(negedge clk_i);
    reg_rd_i = 1'b0; rd_en_i = 1'b0;
    check("R7 pulse on collision", {31'b0, err_pulse_o}, 32'h1);
    check("R7 collided error latched", rdata_o, 32'h0000_0FFC);
    check("R8 reserved bits with full address", rdata_o & 32'hFFFF_F003, 32'h0);
    @(negedge clk_i);
  endtask

  task automatic t_repair();
    mem_write(10'd5, 32'h0000_0007, 1'b1);
    mem_read(10'd5, 1'b0, "R9 rewrite restores parity");
    mem_write(10'd12, 32'h0000_0001, 1'b1);
    mem_read(10'd12, 1'b0, "R9 rewrite with new data");
    check("R4 clean reads leave field", rdata_o, 32'h0000_0FFC);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    #1 check("R8 reserved bits in reset", rdata_o & 32'hFFFF_F003, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_clean();
    t_first();
    t_hold();
    t_dbg();
    t_release();
    t_same_cycle();
    t_repair();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule